// File: doc/BRIEF.md
# Dual-Port Stride Copy Engine

This block drives two auto-stepping access ports, A and B, onto one byte-wide local memory. Each port keeps its own address pointer, a signed step and a repeat counter. A write to a port's data register stores that byte at the port's pointer and moves the pointer by its step. A write to its repeat register then repeats that store once per clock for the given count, so a region can be filled at one byte per cycle while the controlling agent goes on with other work.

A mode bit turns port B's repeat register into a copy trigger. With the bit set, a repeat write on B starts a memory-to-memory transfer: each cycle, port A reads one byte at its pointer and port B writes that byte at its own pointer, and both pointers then step independently. The memory is reached through two access slots per clock. Slot 0 always belongs to port A and is performed before slot 1, which belongs to port B. In copy mode the read data that slot 0 returns is the write data of slot 1 in the same cycle. B's remaining count is exposed as status. Each port has a done output, so an external command sequencer can stall until that port is idle.

Top module: `dual_stride_mover`

## Requirements
- R1: After reset, b_remain is 0, a_done and b_done are 1, copy mode is off, and neither slot requests an access.
- R2: cfg_sel selects the register (0 pointer, 1 step, 2 data, 3 repeat, 4 control) and cfg_port selects the port (0 = A, 1 = B). A data write to an idle port issues a write of the byte in that same cycle, at the port's pointer, on the port's slot (A on slot 0, B on slot 1). The pointer then moves by the step, read as a two's complement value, modulo 2^ADDR_W.
- R3: Outside a copy, a repeat write of value v (low REP_W bits, 0 meaning 2^REP_W) makes the port write its last data byte on each of the next N cycles at successive stepped addresses. Its done output returns to 1 after exactly N cycles.
- R4: Both ports can run fills at the same time, each at one byte per cycle. Slot 0 (port A) is ordered before slot 1 (port B), so when both write the same address in one cycle, B's byte is what remains.
- R5: With control bit 0 set, a repeat write on B of N bytes starts a copy that lasts exactly N cycles. In each of those cycles slot 0 reads at A's pointer and slot 1 writes the byte read at B's pointer.
- R6: During a copy the source and destination steps apply independently; a source step of +1 with a destination step of -1 stores the block in reverse order.
- R7: b_remain shows B's count of bytes still to move, which falls by one per cycle and reads 0 when finished. b_done is 1 exactly when that count is 0. a_done is 0 while A fills or while a copy runs.
- R8: A control write that clears bit 0 during a copy lets the transfer of that cycle complete and then ends the copy. b_remain reads 0 and no further slot access follows.
- R9: Writes are ignored to a busy port's pointer, step, data or repeat registers (port A counts as busy during a copy). A repeat write on A is ignored while copy mode is on. A repeat write on B is ignored while copy mode is on and A is still filling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_port | input | 1 | Port select, 0 = A, 1 = B |
| cfg_sel | input | 3 | Register select |
| cfg_wval | input | ADDR_W | Register write value |
| s0_en | output | 1 | Slot 0 (port A) access request |
| s0_we | output | 1 | Slot 0 write, otherwise read |
| s0_addr | output | ADDR_W | Slot 0 address |
| s0_wdata | output | DATA_W | Slot 0 write data |
| s0_rdata | input | DATA_W | Slot 0 read data, valid in the same cycle |
| s1_en | output | 1 | Slot 1 (port B) access request |
| s1_we | output | 1 | Slot 1 write, otherwise read |
| s1_addr | output | ADDR_W | Slot 1 address |
| s1_wdata | output | DATA_W | Slot 1 write data |
| a_done | output | 1 | Port A idle, used to release a waiting sequencer |
| b_done | output | 1 | Port B idle |
| b_remain | output | REP_W+1 | Bytes still to move on port B |

## Verification
The assertions check the rules that hold on every cycle. A running count always falls by exactly one. A pointer always moves by its own step after an access. A copy cycle always pairs a slot 0 read with a slot 1 write of the same byte. A copy never runs with the mode bit off, an abort always leaves B idle, and nothing reaches the slots while both ports are idle and no write is presented. Only the bench scenarios can show what ends up in memory: byte order after a reversed copy, which value survives a same-address collision between the ports, the exact cycle count of a fill or copy, and that ignored writes leave memory and status untouched.

// File: rtl/mover_pkg.sv
`timescale 1ns/1ps
package mover_pkg;
   typedef enum logic [2:0] {
      REG_PTR  = 3'd0,
      REG_STEP = 3'd1,
      REG_DATA = 3'd2,
      REG_REP  = 3'd3,
      REG_CTRL = 3'd4
   } mover_reg_e;

   localparam int PORT_A = 0;
   localparam int PORT_B = 1;
endpackage

// File: rtl/mover_port.sv
`timescale 1ns/1ps
module mover_port #(
   parameter int ADDR_W = 10,
   parameter int STEP_W = 8,
   parameter int REP_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_ptr,
   input  logic              ld_step,
   input  logic              ld_data,
   input  logic              ld_rep,
   input  logic [ADDR_W-1:0] wval,
   input  logic              adv,
   input  logic              abort,
   output logic [ADDR_W-1:0] ptr,
   output logic [DATA_W-1:0] last,
   output logic [REP_W:0]    cnt
);
   localparam int CNT_W = REP_W + 1;
   localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << REP_W;

   logic [STEP_W-1:0] step_q;
   logic [ADDR_W-1:0] step_ext;
   logic [CNT_W-1:0]  rep_load;

   assign step_ext = ADDR_W'($signed(step_q));
   assign rep_load = (wval[REP_W-1:0] == '0) ? FULL : {1'b0, wval[REP_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         step_q <= '0;
         last   <= '0;
      end else begin
         if (ld_ptr)
            ptr <= wval;
         else if (adv)
            ptr <= ptr + step_ext;
         if (ld_step)
            step_q <= wval[STEP_W-1:0];
         if (ld_data)
            last <= wval[DATA_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (abort)
         cnt <= '0;
      else if (ld_rep)
         cnt <= rep_load;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   AST_CNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && !abort && !ld_rep) |=> (cnt == $past(cnt) - 1'b1)); // R3
   AST_PTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ld_ptr) |=> (ptr == $past(ptr) + $past(step_ext))); // R2
endmodule

// File: rtl/mover_ctl.sv
`timescale 1ns/1ps
module mover_ctl
   import mover_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic       cfg_port,
   input  logic [2:0] cfg_sel,
   input  logic       ctrl_bit,
   input  logic       a_busy,
   input  logic       b_busy,
   output logic [1:0] ld_ptr,
   output logic [1:0] ld_step,
   output logic [1:0] ld_data,
   output logic [1:0] ld_rep,
   output logic       copy_on,
   output logic       abort_b
);
   logic       copy_mode_q;
   logic       b_copy_q;
   logic [1:0] lock;
   logic [1:0] port_hit;
   logic       ctrl_wr;

   assign copy_on  = b_copy_q & b_busy;
   assign lock[PORT_A] = a_busy | copy_on;
   assign lock[PORT_B] = b_busy;
   assign port_hit = {cfg_we & cfg_port, cfg_we & ~cfg_port};
   assign ctrl_wr  = cfg_we && (cfg_sel == REG_CTRL);

   for (genvar gp = 0; gp < 2; gp++) begin : g_dec
      assign ld_ptr[gp]  = port_hit[gp] && (cfg_sel == REG_PTR)  && !lock[gp];
      assign ld_step[gp] = port_hit[gp] && (cfg_sel == REG_STEP) && !lock[gp];
      assign ld_data[gp] = port_hit[gp] && (cfg_sel == REG_DATA) && !lock[gp];
   end

   assign ld_rep[PORT_A] = port_hit[PORT_A] && (cfg_sel == REG_REP) && !lock[PORT_A] && !copy_mode_q;
   assign ld_rep[PORT_B] = port_hit[PORT_B] && (cfg_sel == REG_REP) && !lock[PORT_B]
                           && !(copy_mode_q && a_busy);
   assign abort_b = ctrl_wr && !ctrl_bit && copy_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         copy_mode_q <= 1'b0;
         b_copy_q    <= 1'b0;
      end else begin
         if (ctrl_wr)
            copy_mode_q <= ctrl_bit;
         if (ld_rep[PORT_B])
            b_copy_q <= copy_mode_q;
         else if (abort_b)
            b_copy_q <= 1'b0;
      end
   end

   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      abort_b |=> (!copy_on && !b_busy)); // R8
   AST_COPY_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      copy_on |-> copy_mode_q); // R5
endmodule

// File: rtl/mover_slots.sv
`timescale 1ns/1ps
module mover_slots #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              a_fill,
   input  logic              b_run,
   input  logic              copy_on,
   input  logic              a_wr,
   input  logic              b_wr,
   input  logic [ADDR_W-1:0] ptr_a,
   input  logic [ADDR_W-1:0] ptr_b,
   input  logic [DATA_W-1:0] last_a,
   input  logic [DATA_W-1:0] last_b,
   input  logic [DATA_W-1:0] wbyte,
   input  logic [DATA_W-1:0] s0_rdata,
   output logic              s0_en,
   output logic              s0_we,
   output logic [ADDR_W-1:0] s0_addr,
   output logic [DATA_W-1:0] s0_wdata,
   output logic              s1_en,
   output logic              s1_we,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [DATA_W-1:0] s1_wdata
);
   assign s0_addr = ptr_a;
   assign s1_addr = ptr_b;

   always_comb begin
      s0_en    = 1'b0;
      s0_we    = 1'b0;
      s0_wdata = last_a;
      if (a_fill) begin
         s0_en = 1'b1;
         s0_we = 1'b1;
      end else if (copy_on) begin
         s0_en = 1'b1;
      end else if (a_wr) begin
         s0_en    = 1'b1;
         s0_we    = 1'b1;
         s0_wdata = wbyte;
      end
   end

   always_comb begin
      s1_en    = 1'b0;
      s1_we    = 1'b0;
      s1_wdata = last_b;
      if (b_run) begin
         s1_en    = 1'b1;
         s1_we    = 1'b1;
         s1_wdata = copy_on ? s0_rdata : last_b;
      end else if (b_wr) begin
         s1_en    = 1'b1;
         s1_we    = 1'b1;
         s1_wdata = wbyte;
      end
   end
endmodule

// File: rtl/dual_stride_mover.sv
`timescale 1ns/1ps
module dual_stride_mover #(
   parameter int ADDR_W = 10,
   parameter int STEP_W = 8,
   parameter int REP_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_port,
   input  logic [2:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wval,
   output logic              s0_en,
   output logic              s0_we,
   output logic [ADDR_W-1:0] s0_addr,
   output logic [DATA_W-1:0] s0_wdata,
   input  logic [DATA_W-1:0] s0_rdata,
   output logic              s1_en,
   output logic              s1_we,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [DATA_W-1:0] s1_wdata,
   output logic              a_done,
   output logic              b_done,
   output logic [REP_W:0]    b_remain
);
   if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W out of range");
   end
   if (STEP_W > ADDR_W || DATA_W > ADDR_W || REP_W > ADDR_W) begin : g_bad_width
      $error("STEP_W, DATA_W and REP_W must fit in ADDR_W");
   end

   logic [1:0]        ld_ptr, ld_step, ld_data, ld_rep, adv, abort;
   logic [ADDR_W-1:0] ptr_q  [2];
   logic [DATA_W-1:0] last_q [2];
   logic [REP_W:0]    cnt_q  [2];
   logic              copy_on, abort_b, a_busy, b_busy;

   assign a_busy = (cnt_q[0] != '0);
   assign b_busy = (cnt_q[1] != '0);
   assign adv    = {s1_en, s0_en};
   assign abort  = {abort_b, 1'b0};

   mover_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
      .cfg_sel(cfg_sel), .ctrl_bit(cfg_wval[0]), .a_busy(a_busy), .b_busy(b_busy),
      .ld_ptr(ld_ptr), .ld_step(ld_step), .ld_data(ld_data), .ld_rep(ld_rep),
      .copy_on(copy_on), .abort_b(abort_b)
   );

   for (genvar gp = 0; gp < 2; gp++) begin : g_port
      mover_port #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .REP_W(REP_W), .DATA_W(DATA_W)) u_port (
         .clk(clk), .rst_n(rst_n), .ld_ptr(ld_ptr[gp]), .ld_step(ld_step[gp]),
         .ld_data(ld_data[gp]), .ld_rep(ld_rep[gp]), .wval(cfg_wval),
         .adv(adv[gp]), .abort(abort[gp]), .ptr(ptr_q[gp]), .last(last_q[gp]),
         .cnt(cnt_q[gp])
      );
   end

   mover_slots #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slots (
      .a_fill(a_busy), .b_run(b_busy), .copy_on(copy_on),
      .a_wr(ld_data[0]), .b_wr(ld_data[1]),
      .ptr_a(ptr_q[0]), .ptr_b(ptr_q[1]), .last_a(last_q[0]), .last_b(last_q[1]),
      .wbyte(cfg_wval[DATA_W-1:0]), .s0_rdata(s0_rdata),
      .s0_en(s0_en), .s0_we(s0_we), .s0_addr(s0_addr), .s0_wdata(s0_wdata),
      .s1_en(s1_en), .s1_we(s1_we), .s1_addr(s1_addr), .s1_wdata(s1_wdata)
   );

   assign a_done   = !a_busy && !copy_on;
   assign b_done   = !b_busy;
   assign b_remain = cnt_q[1];

   AST_COPY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      copy_on |-> (s0_en && !s0_we && s1_en && s1_we && s1_wdata == s0_rdata)); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (a_done && b_done && !cfg_we) |-> (!s0_en && !s1_en)); // R1
endmodule

// File: tb/sim_dual_stride_mover.sv
`timescale 1ns/1ps
module sim_dual_stride_mover;
   localparam int AW = 10;
   localparam int MSK = (1 << AW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0, cfg_port = 1'b0;
   logic [2:0]    cfg_sel = '0;
   logic [AW-1:0] cfg_wval = '0;
   logic          s0_en, s0_we, s1_en, s1_we, a_done, b_done;
   logic [AW-1:0] s0_addr, s1_addr;
   logic [7:0]    s0_wdata, s0_rdata, s1_wdata;
   logic [8:0]    b_remain;
   logic [7:0]    mem [0:MSK];
   logic          mem_clr = 1'b0, mem_pat = 1'b0;
   int            total = 0, fails = 0, cyc = 0;

   dual_stride_mover u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
      .cfg_sel(cfg_sel), .cfg_wval(cfg_wval),
      .s0_en(s0_en), .s0_we(s0_we), .s0_addr(s0_addr), .s0_wdata(s0_wdata),
      .s0_rdata(s0_rdata), .s1_en(s1_en), .s1_we(s1_we), .s1_addr(s1_addr),
      .s1_wdata(s1_wdata), .a_done(a_done), .b_done(b_done), .b_remain(b_remain)
   );

   always #10 clk = ~clk;

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 7 + 3) & 255);
   endfunction

   // memory model: slot 0 applied first, slot 1 second
   assign s0_rdata = mem[s0_addr];
   always @(posedge clk) begin
      if (mem_clr) begin
         for (int i = 0; i <= MSK; i++) mem[i] <= 8'h00;
      end else if (mem_pat) begin
         for (int i = 0; i <= MSK; i++) mem[i] <= pat(i);
      end else begin
         if (s0_en && s0_we) mem[s0_addr] <= s0_wdata;
         if (s1_en && s1_we) mem[s1_addr] <= s1_wdata;
      end
   end

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++; fails++;
         $display("FAIL R7 watchdog actual=%0d expected<150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // R2 encoding: sel 0 ptr, 1 step, 2 data, 3 repeat, 4 control
   task automatic wr(input int p, input int sel, input int val);
      cfg_port = p[0]; cfg_sel = sel[2:0]; cfg_wval = val[AW-1:0]; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_port(input int p, output int k);
      k = 0;
      while (((p == 0) ? !a_done : !b_done) && k < 2000) begin
         @(negedge clk); k++;
      end
   endtask

   task automatic fill_mem(input bit with_pat);
      if (with_pat) mem_pat = 1'b1; else mem_clr = 1'b1;
      @(negedge clk);
      mem_pat = 1'b0; mem_clr = 1'b0;
   endtask

   typedef struct packed {
      logic       port;
      logic [9:0] ptr;
      logic [7:0] step;
      logic [7:0] data;
      logic [7:0] rep;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{1'b0, 10'd16,   8'd1,   8'h11, 8'd3},
      '{1'b1, 10'd100,  8'hFE,  8'h22, 8'd5},
      '{1'b0, 10'd1020, 8'd3,   8'h33, 8'd4},
      '{1'b1, 10'd200,  8'd4,   8'h44, 8'd2},
      '{1'b0, 10'd500,  8'd1,   8'h55, 8'd0}
   };

   initial begin
      int k, n, bad, nz, s;
      @(negedge clk); @(negedge clk);
      // R1 reset state
      chk("R1 b_remain", int'(b_remain), 0);
      chk("R1 a_done", int'(a_done), 1);
      chk("R1 b_done", int'(b_done), 1);
      chk("R1 slots idle", int'(s0_en | s1_en), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: data write then repeat fill (R2, R3)
      foreach (VECS[vi]) begin
         fill_mem(1'b0);
         wr(VECS[vi].port, 0, VECS[vi].ptr);
         wr(VECS[vi].port, 1, VECS[vi].step);
         wr(VECS[vi].port, 2, VECS[vi].data);
         wr(VECS[vi].port, 3, VECS[vi].rep);
         n = (VECS[vi].rep == 0) ? 256 : int'(VECS[vi].rep);
         wait_port(VECS[vi].port, k);
         chk("R3 fill cycles", k, n);
         s = int'($signed(VECS[vi].step));
         bad = 0;
         for (int j = 0; j <= n; j++)
            if (mem[(int'(VECS[vi].ptr) + j * s) & MSK] != VECS[vi].data) bad++;
         chk("R2 R3 stepped bytes wrong", bad, 0);
         nz = 0;
         for (int i = 0; i <= MSK; i++) if (mem[i] != 8'h00) nz++;
         chk("R3 bytes written", nz, n + 1);
      end

      // R4: concurrent fills, same-address collision keeps B's byte
      fill_mem(1'b0);
      wr(0, 0, 600); wr(0, 1, 1); wr(1, 0, 601); wr(1, 1, 1);
      wr(0, 2, 8'hAA); wr(1, 2, 8'hBB);
      wr(0, 3, 3); wr(1, 3, 3);
      chk("R4 both busy", int'(!a_done && !b_done), 1);
      wait_port(1, k);
      chk("R4 mem600", int'(mem[600]), 8'hAA);
      chk("R4 mem601", int'(mem[601]), 8'hAA);
      chk("R4 mem602 B wins", int'(mem[602]), 8'hBB);
      chk("R4 mem603 B wins", int'(mem[603]), 8'hBB);
      chk("R4 mem604", int'(mem[604]), 8'hBB);

      // R5 R6 R7: reversed copy of 200 bytes
      fill_mem(1'b1);
      wr(0, 0, 40); wr(0, 1, 1); wr(1, 0, 899); wr(1, 1, 8'hFF);
      wr(0, 4, 1);
      wr(1, 3, 200);
      chk("R7 remain at start", int'(b_remain), 200);
      chk("R7 a_done low in copy", int'(a_done), 0);
      for (int i = 0; i < 10; i++) @(negedge clk);
      chk("R7 remain after 10", int'(b_remain), 190);
      wait_port(1, k);
      chk("R5 copy cycles", k + 10, 200);
      chk("R7 remain end", int'(b_remain), 0);
      bad = 0;
      for (int j = 0; j < 200; j++) if (mem[899 - j] != pat(40 + j)) bad++;
      chk("R6 reversed bytes wrong", bad, 0);
      chk("R5 byte past block", int'(mem[699]), int'(pat(699)));

      // R8: abort in the middle of a copy
      fill_mem(1'b1);
      wr(0, 0, 40); wr(1, 0, 300); wr(1, 1, 1);
      wr(1, 3, 100);
      for (int i = 0; i < 4; i++) @(negedge clk);
      wr(0, 4, 0);
      chk("R8 remain zero", int'(b_remain), 0);
      chk("R8 b_done", int'(b_done), 1);
      chk("R8 slots quiet", int'(s0_en | s1_en), 0);
      bad = 0;
      for (int j = 0; j < 5; j++) if (mem[300 + j] != pat(40 + j)) bad++;
      chk("R8 bytes before abort", bad, 0);
      chk("R8 byte after abort", int'(mem[305]), int'(pat(305)));

      // R9: writes to a busy port are ignored
      fill_mem(1'b0);
      wr(0, 0, 100); wr(0, 1, 1); wr(0, 2, 8'h66); wr(0, 3, 10);
      wr(0, 0, 900);
      wr(0, 2, 8'h77);
      wait_port(0, k);
      bad = 0;
      for (int j = 0; j <= 10; j++) if (mem[100 + j] != 8'h66) bad++;
      chk("R9 busy writes ignored", bad, 0);
      chk("R9 no stray write", int'(mem[900]) + int'(mem[111]), 0);
      wr(0, 4, 1);
      wr(0, 3, 5);
      chk("R9 A repeat ignored in copy mode", int'(a_done), 1);
      wr(0, 4, 0);
      wr(0, 3, 20);
      wr(0, 4, 1);
      wr(1, 3, 5);
      chk("R9 copy start ignored while A fills", int'(b_remain), 0);
      wait_port(0, k);
      wr(0, 4, 0);

      summary();
      $finish;
   end
endmodule